// File: doc/BRIEF.md
# SDRAM Refresh and Power-Down Sequencer

This block sits beside a DDR SDRAM command scheduler. It keeps the device's contents alive and manages its clock-enable line. A free-running interval counter produces one refresh request per average refresh period. Each request adds one unit to a credit (debt) counter. Whenever the sequencer is idle with credit pending, it issues an auto refresh. If any bank is still open, it first issues a precharge-all and waits the precharge time. After an auto refresh it holds the command bus for the refresh cycle time.

Power-down and self-refresh are requested by level inputs. Entering either one drives CKE low. While CKE is low in power-down, refreshes are postponed and counted. When the postponed count reaches its limit, the sequencer leaves power-down by itself and issues the owed refreshes back to back. Self-refresh entry discards the owed credit. On self-refresh exit the sequencer restarts the interval counter and enforces two separate delays: a short one before any non-read command and a long one before a read.

The scheduler may put its own commands on the bus only while the matching ready output is high.

Top module: `refresh_pwr_seq`

## Requirements
- R1: After reset, CKE is high, no command is requested (cmd_valid low, cmd_code 0), and both ready outputs are high while no request is present.
- R2: One refresh credit is added every REFI_CLKS cycles. The first credit is added REFI_CLKS cycles after reset is released. With all banks idle and no other request, the auto refresh command (cmd_code 2) appears REFI_CLKS+1 cycles after reset release and then every REFI_CLKS cycles.
- R3: If banks_idle is low when a refresh is started, a precharge-all command (cmd_code 1) is issued first, and the auto refresh follows exactly RP_CLKS cycles after it.
- R4: After an auto refresh, ready_nonread stays low for RFC_CLKS cycles and no other command is issued. It is high again RFC_CLKS cycles after the refresh if nothing else is pending.
- R5: A power-down request in idle with no credit pending drives CKE low from the next cycle. No command is issued while CKE is low, except the self-refresh entry.
- R6: When the power-down request is withdrawn, CKE goes high and ready_nonread is held low for PDX_CLKS cycles, becoming high PDX_CLKS cycles after CKE rose.
- R7: Refresh credit accumulates during power-down and never exceeds MAX_DEBT. When it reaches MAX_DEBT, the sequencer leaves power-down by itself, issues MAX_DEBT auto refreshes, and re-enters power-down if the request is still present.
- R8: A self-refresh request takes priority over pending refresh credit. If banks are open, a precharge-all comes first. The self-refresh entry command (cmd_code 3) follows RP_CLKS cycles later, with CKE low in the same cycle.
- R9: While in self-refresh, CKE stays low and no command is issued.
- R10: When the self-refresh request is withdrawn, CKE rises and ready_nonread becomes high exactly SRX_NONREAD_CLKS cycles later.
- R11: ready_read becomes high exactly SRX_READ_CLKS cycles after the self-refresh exit, and ready_read is never high while ready_nonread is low.
- R12: Entering self-refresh clears all credit, and the interval restarts at exit. The first auto refresh after exit appears REFI_CLKS+1 cycles after CKE rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request (level) |
| sr_req | input | 1 | Self-refresh request (level) |
| banks_idle | input | 1 | High when every bank is precharged |
| cke | output | 1 | Clock-enable line to the device |
| cmd_valid | output | 1 | A sequencer command is presented this cycle |
| cmd_code | output | 2 | 0 none, 1 precharge-all, 2 auto refresh, 3 self-refresh entry |
| ready_nonread | output | 1 | Scheduler may issue a non-read command |
| ready_read | output | 1 | Scheduler may issue a read command |

## Verification
The refresh cadence is first measured with banks idle and then with banks open. This separates the plain refresh path from the precharge-first path and its exact precharge spacing. Power-down is held for a short time and a long time. The short hold shows the exit delay alone, with no refresh owed. The long hold shows postponement and the forced exit with exactly the owed number of refreshes.

A self-refresh entered while credit is owed, with banks open, distinguishes priority, credit clearing and interval restart, and times both exit delays. A random phase toggles the power-down request and bank status. During it, command spacing, ready rules and the total refresh count are checked against the elapsed time.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PREA = 2'd1,
    CMD_REF  = 2'd2,
    CMD_SRE  = 2'd3
  } seq_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_REF, ST_PD, ST_PDX, ST_SR, ST_SRX
  } seq_st_e;
endpackage

// File: rtl/rps_interval.sv
module rps_interval #(
  parameter int REFI_CLKS = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int W = $clog2(REFI_CLKS);
  localparam logic [W-1:0] RELOAD = W'(REFI_CLKS - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = !hold && (cnt_q == '0);
    if (hold || cnt_q == '0) cnt_d = RELOAD;
    else                     cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rps_debt.sv
module rps_debt #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = $clog2(MAX_DEBT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dec,
  input  logic          clr,
  output logic [DW-1:0] debt,
  output logic          pending,
  output logic          at_max
);
  logic [DW-1:0] debt_d;

  always_comb begin
    if (clr)               debt_d = '0;
    else if (tick && !dec) debt_d = debt + DW'(1);
    else if (dec && !tick) debt_d = debt - DW'(1);
    else                   debt_d = debt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt <= '0;
    else        debt <= debt_d;
  end

  assign pending = (debt != '0);
  assign at_max  = (debt >= DW'(MAX_DEBT));
endmodule

// File: rtl/rps_read_gate.sv
module rps_read_gate #(
  parameter int SRX_READ_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic rd_ok
);
  localparam int RW = $clog2(SRX_READ_CLKS + 1);

  logic [RW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = RW'(SRX_READ_CLKS);
    else if (cnt_q != '0)  cnt_d = cnt_q - RW'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rd_ok = (cnt_q == '0);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
#(
  parameter int RFC_CLKS         = 14,
  parameter int RP_CLKS          = 4,
  parameter int SRX_NONREAD_CLKS = 15,
  parameter int PDX_CLKS         = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pd_req,
  input  logic     sr_req,
  input  logic     banks_idle,
  input  logic     pending,
  input  logic     at_max,
  output seq_st_e  state,
  output seq_cmd_e cmd,
  output logic     issue_ref,
  output logic     enter_sr,
  output logic     leave_sr,
  output logic     idle_free
);
  localparam int M1   = (RFC_CLKS > RP_CLKS) ? RFC_CLKS : RP_CLKS;
  localparam int M2   = (SRX_NONREAD_CLKS > PDX_CLKS) ? SRX_NONREAD_CLKS : PDX_CLKS;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 1);

  seq_st_e       st_d;
  seq_cmd_e      cmd_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tgt_sr_q, tgt_sr_d;

  always_comb begin
    st_d     = state;
    cmd_d    = CMD_NONE;
    tgt_sr_d = tgt_sr_q;
    tmr_d    = (tmr_q != '0) ? tmr_q - TW'(1) : tmr_q;
    unique case (state)
      ST_IDLE: begin
        if (sr_req || pending) begin
          if (!banks_idle) begin
            st_d     = ST_PRE;
            cmd_d    = CMD_PREA;
            tmr_d    = TW'(RP_CLKS - 1);
            tgt_sr_d = sr_req;
          end else if (sr_req) begin
            st_d  = ST_SR;
            cmd_d = CMD_SRE;
          end else begin
            st_d  = ST_REF;
            cmd_d = CMD_REF;
            tmr_d = TW'(RFC_CLKS - 1);
          end
        end else if (pd_req) begin
          st_d = ST_PD;
        end
      end
      ST_PRE: begin
        if (tmr_q == '0) begin
          if (tgt_sr_q) begin
            st_d  = ST_SR;
            cmd_d = CMD_SRE;
          end else begin
            st_d  = ST_REF;
            cmd_d = CMD_REF;
            tmr_d = TW'(RFC_CLKS - 1);
          end
        end
      end
      ST_REF, ST_PDX, ST_SRX: begin
        if (tmr_q == '0) st_d = ST_IDLE;
      end
      ST_PD: begin
        if (!pd_req || sr_req || at_max) begin
          st_d  = ST_PDX;
          tmr_d = TW'(PDX_CLKS - 1);
        end
      end
      ST_SR: begin
        if (!sr_req) begin
          st_d  = ST_SRX;
          tmr_d = TW'(SRX_NONREAD_CLKS - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign issue_ref = (cmd_d == CMD_REF);
  assign enter_sr  = (cmd_d == CMD_SRE);
  assign leave_sr  = (state == ST_SR) && (st_d == ST_SRX);
  assign idle_free = (state == ST_IDLE) && !sr_req && !pending && !pd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd      <= CMD_NONE;
      tmr_q    <= '0;
      tgt_sr_q <= 1'b0;
    end else begin
      state    <= st_d;
      cmd      <= cmd_d;
      tmr_q    <= tmr_d;
      tgt_sr_q <= tgt_sr_d;
    end
  end
endmodule

// File: rtl/refresh_pwr_seq.sv
module refresh_pwr_seq
  import rps_pkg::*;
#(
  parameter int REFI_CLKS        = 1560,
  parameter int MAX_DEBT         = 8,
  parameter int RFC_CLKS         = 14,
  parameter int RP_CLKS          = 4,
  parameter int SRX_NONREAD_CLKS = 15,
  parameter int SRX_READ_CLKS    = 200,
  parameter int PDX_CLKS         = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       sr_req,
  input  logic       banks_idle,
  output logic       cke,
  output logic       cmd_valid,
  output logic [1:0] cmd_code,
  output logic       ready_nonread,
  output logic       ready_read
);
  localparam int DW = $clog2(MAX_DEBT + 2);

  seq_st_e       st;
  seq_cmd_e      cmd_e;
  logic          tick, issue_ref, enter_sr, leave_sr;
  logic          pending, at_max, rd_ok, idle_free;
  logic [DW-1:0] debt_w;

  rps_interval #(.REFI_CLKS(REFI_CLKS)) u_interval (
    .clk(clk), .rst_n(rst_n), .hold(st == ST_SR), .tick(tick)
  );

  rps_debt #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(issue_ref), .clr(enter_sr),
    .debt(debt_w), .pending(pending), .at_max(at_max)
  );

  rps_fsm #(
    .RFC_CLKS(RFC_CLKS), .RP_CLKS(RP_CLKS),
    .SRX_NONREAD_CLKS(SRX_NONREAD_CLKS), .PDX_CLKS(PDX_CLKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
    .banks_idle(banks_idle), .pending(pending), .at_max(at_max),
    .state(st), .cmd(cmd_e), .issue_ref(issue_ref), .enter_sr(enter_sr),
    .leave_sr(leave_sr), .idle_free(idle_free)
  );

  rps_read_gate #(.SRX_READ_CLKS(SRX_READ_CLKS)) u_rd_gate (
    .clk(clk), .rst_n(rst_n), .load(leave_sr), .rd_ok(rd_ok)
  );

  assign cke           = !((st == ST_PD) || (st == ST_SR));
  assign cmd_valid     = (cmd_e != CMD_NONE);
  assign cmd_code      = cmd_e;
  assign ready_nonread = idle_free;
  assign ready_read    = idle_free && rd_ok;
endmodule

// File: rtl/rps_checker.sv
module rps_checker
  import rps_pkg::*;
#(
  parameter int MAX_DEBT = 8,
  parameter int DW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          cmd_valid,
  input logic [1:0]    cmd_code,
  input logic          ready_nonread,
  input logic          ready_read,
  input logic [DW-1:0] debt
);
  assert_sre_cke_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_SRE) |-> !cke);

  assert_ref_cke_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_REF) |-> (cke && $past(cke)));

  assert_low_cke_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cmd_valid || cmd_code == CMD_SRE));

  assert_ref_blocks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_REF) |=> !ready_nonread);

  assert_cmd_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !ready_nonread);

  assert_exit_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !ready_nonread);

  assert_prea_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PREA) |=> !cmd_valid);

  assert_read_implies_nonread_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready_read |-> ready_nonread);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(MAX_DEBT));
endmodule

bind refresh_pwr_seq rps_checker #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_rps_checker (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .ready_nonread(ready_nonread), .ready_read(ready_read),
  .debt(debt_w)
);

// File: tb/test_refresh_pwr_seq.sv
module test_refresh_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int REFI = 60;
  localparam int MAXD = 3;
  localparam int RFC  = 6;
  localparam int RP   = 3;
  localparam int SRNR = 5;
  localparam int SRRD = 20;
  localparam int PDX  = 2;
  localparam logic [1:0] C_PREA = 2'd1, C_REF = 2'd2, C_SRE = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0, sr_req = 1'b0, banks_idle = 1'b1;
  logic cke, cmd_valid, ready_nonread, ready_read;
  logic [1:0] cmd_code;

  int cyc = 0;
  int nchecks = 0;
  int nfail = 0;
  int refs = 0;
  bit mon_en = 1'b0;
  logic [1:0] last_cmd = 2'd0;
  int last_at = 0;

  refresh_pwr_seq #(
    .REFI_CLKS(REFI), .MAX_DEBT(MAXD), .RFC_CLKS(RFC), .RP_CLKS(RP),
    .SRX_NONREAD_CLKS(SRNR), .SRX_READ_CLKS(SRRD), .PDX_CLKS(PDX)
  ) i_refresh_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
    .banks_idle(banks_idle), .cke(cke), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .ready_nonread(ready_nonread), .ready_read(ready_read)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Port monitor: spacing and ready rules
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (cmd_valid) begin
        if (cmd_code == C_PREA) begin
          last_cmd = C_PREA; last_at = cyc;
        end else if (cmd_code == C_REF) begin
          refs++;
          if (last_cmd == C_PREA) check(cyc - last_at == RP, "R3 prea-to-ref gap", cyc - last_at, RP);
          else if (last_cmd == C_REF) check(cyc - last_at >= RFC, "R4 ref-to-ref gap", cyc - last_at, RFC);
          check(cke == 1'b1, "R5 ref with cke high", int'(cke), 1);
          last_cmd = C_REF; last_at = cyc;
        end else if (cmd_code == C_SRE) begin
          check(cke == 1'b0, "R8 sre with cke low", int'(cke), 0);
          last_cmd = C_SRE; last_at = cyc;
        end
      end
      if (ready_nonread) begin
        check(cke && last_cmd != C_PREA && !(last_cmd == C_REF && cyc - last_at < RFC),
              "R4 ready outside refresh window", cyc - last_at, RFC);
      end
      if (ready_read) check(ready_nonread == 1'b1, "R11 read ready implies nonread ready", int'(ready_nonread), 1);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic pd, input logic sr, input logic bi);
    #1;
    pd_req = pd; sr_req = sr; banks_idle = bi;
  endtask

  task automatic wait_cmd(input logic [1:0] code, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (cmd_valid && cmd_code == code) begin at = cyc; break; end
    end
  endtask

  task automatic wait_cke(input logic val, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (cke == val) begin at = cyc; break; end
    end
  endtask

  function automatic int first_ref_after(input int start);
    return start + REFI + 1;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired at cycle %0d: actual=1 expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    int t0, t1, e, f, r, n;
    void'($urandom(32'd1234));
    step(4);
    rst_n = 1'b1;
    // R1: reset state
    check(cke == 1'b1, "R1 cke after reset", int'(cke), 1);
    check(cmd_valid == 1'b0 && cmd_code == 2'd0, "R1 no command after reset", int'(cmd_code), 0);
    check(ready_nonread && ready_read, "R1 ready after reset", int'(ready_nonread) + int'(ready_read), 2);
    mon_en = 1'b1;

    // R2: refresh cadence with idle banks
    wait_cmd(C_REF, 3 * REFI, t0);
    check(t0 == first_ref_after(0), "R2 first refresh", t0, first_ref_after(0));
    // R4: ready window after refresh
    step(RFC - 1);
    check(ready_nonread == 1'b0, "R4 ready low before RFC", int'(ready_nonread), 0);
    step(1);
    check(ready_nonread == 1'b1, "R4 ready high at RFC", int'(ready_nonread), 1);
    wait_cmd(C_REF, 3 * REFI, t1);
    check(t1 - t0 == REFI, "R2 refresh interval", t1 - t0, REFI);

    // R3: banks open, precharge-all first
    drive(1'b0, 1'b0, 1'b0);
    wait_cmd(C_PREA, 3 * REFI, t0);
    check(t0 - t1 == REFI, "R3 precharge at refresh slot", t0 - t1, REFI);
    drive(1'b0, 1'b0, 1'b1);
    wait_cmd(C_REF, 10, r);
    check(r - t0 == RP, "R3 refresh after precharge", r - t0, RP);

    // R5/R6: short power-down
    step(RFC);
    drive(1'b1, 1'b0, 1'b1);
    step(1);
    check(cke == 1'b0, "R5 cke low after request", int'(cke), 0);
    step(10);
    check(cke == 1'b0 && !cmd_valid, "R5 cke held low", int'(cke), 0);
    drive(1'b0, 1'b0, 1'b1);
    wait_cke(1'b1, 10, e);
    check(e > 0 && ready_nonread == 1'b0, "R6 not ready at exit", int'(ready_nonread), 0);
    step(PDX - 1);
    check(ready_nonread == 1'b0, "R6 not ready before PDX", int'(ready_nonread), 0);
    step(1);
    check(ready_nonread == 1'b1, "R6 ready at PDX", int'(ready_nonread), 1);

    // R7: long power-down, forced exit
    wait_cmd(C_REF, 3 * REFI, r);
    step(RFC);
    drive(1'b1, 1'b0, 1'b1);
    wait_cke(1'b0, 10, f);
    n = refs;
    wait_cke(1'b1, 5 * REFI, e);
    check(e > 0 && e - f >= 2 * REFI, "R7 refreshes postponed in power-down", e - f, 2 * REFI);
    check(refs == n, "R7 no refresh while cke low", refs - n, 0);
    n = refs;
    wait_cke(1'b0, 100, f);
    check(refs - n == MAXD, "R7 owed refreshes issued", refs - n, MAXD);

    // R8: self-refresh with credit owed and banks open
    step(REFI + REFI / 2);
    n = refs;
    drive(1'b0, 1'b1, 1'b0);
    wait_cmd(C_PREA, 20, t0);
    drive(1'b0, 1'b1, 1'b1);
    wait_cmd(C_SRE, 20, t1);
    check(t0 > 0 && t1 - t0 == RP, "R8 sre after precharge", t1 - t0, RP);
    check(cke == 1'b0, "R8 cke low at sre", int'(cke), 0);
    check(refs == n, "R8 self-refresh before owed refresh", refs - n, 0);
    // R9: quiet while in self-refresh
    n = 0;
    for (int i = 0; i < 4 * REFI; i++) begin
      @(negedge clk);
      if (cke || cmd_valid) n++;
    end
    check(n == 0, "R9 quiet in self-refresh", n, 0);
    drive(1'b0, 1'b0, 1'b1);
    wait_cke(1'b1, 10, e);
    // R10/R11: exit delays
    step(SRNR - 1);
    check(ready_nonread == 1'b0, "R10 not ready before exit delay", int'(ready_nonread), 0);
    step(1);
    check(ready_nonread == 1'b1, "R10 ready at exit delay", int'(ready_nonread), 1);
    check(ready_read == 1'b0, "R11 read blocked after nonread ready", int'(ready_read), 0);
    step(SRRD - SRNR - 1);
    check(ready_read == 1'b0, "R11 read blocked before read delay", int'(ready_read), 0);
    step(1);
    check(ready_read == 1'b1, "R11 read ready at read delay", int'(ready_read), 1);
    // R12: credit cleared, interval restarted
    wait_cmd(C_REF, 3 * REFI, r);
    check(r == first_ref_after(e), "R12 first refresh after self-refresh exit", r, first_ref_after(e));

    // Random phase: R2 totals plus monitor rules
    n = refs;
    t0 = cyc;
    while (cyc - t0 < 2500) begin
      drive(1'($urandom % 2), 1'b0, 1'($urandom % 2));
      step(1 + int'($urandom % 30));
    end
    drive(1'b0, 1'b0, 1'b1);
    check(refs - n >= (cyc - t0) / REFI - MAXD - 1, "R2 refresh count over random run",
          refs - n, (cyc - t0) / REFI - MAXD - 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule